// File: doc/BRIEF.md
# Periodic Match-Action Issue Controller

This block drives one match-action processor that takes in a new packet every `PERIOD` cycles. A compiled static schedule sits in a small table. Each entry gives an operation kind, a cycle offset from the packet's arrival, and an operation index. The controller records every arrival together with its context ID. In each cycle it issues whichever match and whichever action fall due, tagged with the context ID of the packet that owns them. When packets overlap, their operations interleave according to arrival offset modulo `PERIOD`.

The per-cycle budget is one match start and one action start. The controller checks the loaded schedule against that budget by grouping entries on their offset residue. A collision raises a violation flag that stays set until reset. Entries marked as no-op fill slots where a conflicting operation was pushed back, and they never issue. The key lookup, memory access and field arithmetic happen outside this block.

Top module: `periodic_issue_ctl`

## Requirements
- R1: After synchronous reset, `mat_issue`, `act_issue` and `sched_violation` are low and every table entry is a no-op.
- R2: A table entry of kind match (`cfg_kind` = 1) with offset t, for a packet that arrives on clock edge a, produces `mat_issue` high on the output registered at edge a+t, carrying that entry's op index on `mat_op` and the packet's context on `mat_ctx`.
- R3: An entry of kind action (`cfg_kind` = 2) behaves the same way on `act_issue`, `act_op` and `act_ctx`.
- R4: Entries of kind no-op (`cfg_kind` = 0) never produce an issue on either port.
- R5: When packets overlap, each issue carries the context of the packet whose arrival edge plus the entry offset equals the issuing edge.
- R6: A match and an action that fall due on the same edge, even for different packets, both issue on that edge.
- R7: A configuration write is ignored while any packet is in flight, meaning an arrival is present or one arrived within the last 2^OFF_W - 1 edges.
- R8: If the table holds two matches, or two actions, whose offsets are equal modulo `PERIOD`, `sched_violation` rises on the edge after the table reaches that state, and it stays high until reset even if the table is later corrected.
- R9: With the inter-packet setting `IPC` at its default of 2, a match and an action that share a residue at different offsets are legal and do not raise `sched_violation`. With `IPC` = 1, such a pair is flagged.
- R10: Reset clears a raised `sched_violation` and returns the table to all no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | Packet arrival strobe |
| arr_ctx | input | CTX_W | Context ID of the arriving packet |
| cfg_we | input | 1 | Schedule table write strobe |
| cfg_addr | input | $clog2(N_ENT) | Table entry to write |
| cfg_kind | input | 2 | Entry kind: 0 no-op, 1 match, 2 action |
| cfg_off | input | OFF_W | Cycle offset from arrival |
| cfg_opidx | input | OPI_W | Operation index reported on issue |
| mat_issue | output | 1 | Match issue strobe |
| mat_op | output | OPI_W | Operation index of the issued match |
| mat_ctx | output | CTX_W | Context ID of the issued match |
| act_issue | output | 1 | Action issue strobe |
| act_op | output | OPI_W | Operation index of the issued action |
| act_ctx | output | CTX_W | Context ID of the issued action |
| sched_violation | output | 1 | Sticky residue-budget violation flag |

## Verification
The one-hot issue checks assume that arrivals are spaced by whole multiples of `PERIOD`. Under that spacing, a table free of residue conflicts can never have two entries of the same kind due at once. The stimulus therefore sends packets only every `PERIOD` cycles and writes the table only after the in-flight window has drained, except for the single write that deliberately lands while packets are in flight. The busy-write assertion takes nothing for granted about the inputs: it requires the table to stay unchanged whenever a write meets a busy block.

// File: rtl/mai_pkg.sv
package mai_pkg;

    localparam int OFF_W = 5;
    localparam int OPI_W = 6;
    localparam int CTX_W = 8;

    typedef enum logic [1:0] {
        K_NOP    = 2'd0,
        K_MATCH  = 2'd1,
        K_ACTION = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e             kind;
        logic [OFF_W-1:0]     off;
        logic [OPI_W-1:0]     idx;
    } sched_ent_t;

    typedef struct packed {
        logic                 vld;
        logic [OPI_W-1:0]     idx;
        logic [CTX_W-1:0]     ctx;
    } issue_t;

    function automatic int residue_of(input logic [OFF_W-1:0] off, input int period);
        return int'(off) % period;
    endfunction

endpackage

// File: rtl/mai_sched_table.sv
module mai_sched_table #(
    parameter int N_ENT = 32,
    parameter int AW    = $clog2(N_ENT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic                allow,
    input  logic [AW-1:0]       addr,
    input  mai_pkg::sched_ent_t wdata,
    output mai_pkg::sched_ent_t tbl [N_ENT]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < N_ENT; e++) begin
                tbl[e] <= '0;
            end
        end else if (we && allow) begin
            tbl[addr] <= wdata;
        end
    end

endmodule

// File: rtl/mai_arrival_line.sv
module mai_arrival_line #(
    parameter int OFF_W = mai_pkg::OFF_W,
    parameter int CTX_W = mai_pkg::CTX_W,
    localparam int NAGE  = 1 << OFF_W,
    localparam int DEPTH = NAGE - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_v,
    input  logic [CTX_W-1:0] in_c,
    output logic [NAGE-1:0]  age_v,
    output logic [CTX_W-1:0] age_c [NAGE],
    output logic             inflight
);

    logic [DEPTH:1]   sv;
    logic [CTX_W-1:0] sc [1:DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            sv <= '0;
        end else begin
            sv[1] <= in_v;
            for (int k = 2; k <= DEPTH; k++) begin
                sv[k] <= sv[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        sc[1] <= in_c;
        for (int k = 2; k <= DEPTH; k++) begin
            sc[k] <= sc[k-1];
        end
    end

    always_comb begin
        age_v[0] = in_v;
        age_c[0] = in_c;
        for (int k = 1; k <= DEPTH; k++) begin
            age_v[k] = sv[k];
            age_c[k] = sc[k];
        end
    end

    assign inflight = |sv;

endmodule

// File: rtl/mai_residue_check.sv
module mai_residue_check #(
    parameter int N_ENT  = 32,
    parameter int PERIOD = 2,
    parameter int IPC    = 2
) (
    input  mai_pkg::sched_ent_t tbl [N_ENT],
    output logic                conflict
);
    import mai_pkg::*;

    logic same_kind_hit;
    logic cross_hit;

    always_comb begin
        same_kind_hit = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            for (int j = i + 1; j < N_ENT; j++) begin
                if ((tbl[i].kind == tbl[j].kind) &&
                    (tbl[i].kind == K_MATCH || tbl[i].kind == K_ACTION) &&
                    (residue_of(tbl[i].off, PERIOD) == residue_of(tbl[j].off, PERIOD))) begin
                    same_kind_hit = 1'b1;
                end
            end
        end
    end

    generate
        if (IPC == 1) begin : g_single_packet
            always_comb begin
                cross_hit = 1'b0;
                for (int i = 0; i < N_ENT; i++) begin
                    for (int j = 0; j < N_ENT; j++) begin
                        if ((tbl[i].kind == K_MATCH) && (tbl[j].kind == K_ACTION) &&
                            (tbl[i].off != tbl[j].off) &&
                            (residue_of(tbl[i].off, PERIOD) == residue_of(tbl[j].off, PERIOD))) begin
                            cross_hit = 1'b1;
                        end
                    end
                end
            end
        end else begin : g_multi_packet
            assign cross_hit = 1'b0;
        end
    endgenerate

    assign conflict = same_kind_hit | cross_hit;

endmodule

// File: rtl/mai_issue_pick.sv
module mai_issue_pick #(
    parameter int                N_ENT = 32,
    parameter mai_pkg::op_kind_e KIND  = mai_pkg::K_MATCH,
    localparam int NAGE = 1 << mai_pkg::OFF_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  mai_pkg::sched_ent_t      tbl [N_ENT],
    input  logic [NAGE-1:0]          age_v,
    input  logic [mai_pkg::CTX_W-1:0] age_c [NAGE],
    output logic [N_ENT-1:0]         hit,
    output mai_pkg::issue_t          iss
);

    mai_pkg::issue_t pick;

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_hit
            assign hit[g] = (tbl[g].kind == KIND) && age_v[tbl[g].off];
        end
    endgenerate

    always_comb begin
        pick = '0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (hit[e]) begin
                pick.vld = 1'b1;
                pick.idx = tbl[e].idx;
                pick.ctx = age_c[tbl[e].off];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) iss <= '0;
        else     iss <= pick;
    end

endmodule

// File: rtl/periodic_issue_ctl.sv
module periodic_issue_ctl #(
    parameter int N_ENT  = 32,
    parameter int PERIOD = 2,
    parameter int IPC    = 2,
    localparam int AW    = $clog2(N_ENT),
    localparam int OFF_W = mai_pkg::OFF_W,
    localparam int OPI_W = mai_pkg::OPI_W,
    localparam int CTX_W = mai_pkg::CTX_W,
    localparam int NAGE  = 1 << OFF_W,
    localparam int EW    = $bits(mai_pkg::sched_ent_t)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arr_valid,
    input  logic [CTX_W-1:0] arr_ctx,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [1:0]       cfg_kind,
    input  logic [OFF_W-1:0] cfg_off,
    input  logic [OPI_W-1:0] cfg_opidx,
    output logic             mat_issue,
    output logic [OPI_W-1:0] mat_op,
    output logic [CTX_W-1:0] mat_ctx,
    output logic             act_issue,
    output logic [OPI_W-1:0] act_op,
    output logic [CTX_W-1:0] act_ctx,
    output logic             sched_violation
);
    import mai_pkg::*;

    sched_ent_t          tbl [N_ENT];
    sched_ent_t          wdata;
    logic [N_ENT*EW-1:0] tbl_flat;
    logic [NAGE-1:0]     age_v;
    logic [CTX_W-1:0]    age_c [NAGE];
    logic                inflight;
    logic                busy;
    logic                conflict;
    logic [N_ENT-1:0]    mhit;
    logic [N_ENT-1:0]    ahit;
    issue_t              m_iss;
    issue_t              a_iss;

    assign wdata = '{kind: op_kind_e'(cfg_kind), off: cfg_off, idx: cfg_opidx};
    assign busy  = arr_valid | inflight;

    mai_sched_table #(.N_ENT(N_ENT), .AW(AW)) u_table (
        .clk(clk), .rst(rst), .we(cfg_we), .allow(!busy),
        .addr(cfg_addr), .wdata(wdata), .tbl(tbl)
    );

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_flat
            assign tbl_flat[g*EW +: EW] = tbl[g];
        end
    endgenerate

    mai_arrival_line #(.OFF_W(OFF_W), .CTX_W(CTX_W)) u_line (
        .clk(clk), .rst(rst), .in_v(arr_valid), .in_c(arr_ctx),
        .age_v(age_v), .age_c(age_c), .inflight(inflight)
    );

    mai_residue_check #(.N_ENT(N_ENT), .PERIOD(PERIOD), .IPC(IPC)) u_resid (
        .tbl(tbl), .conflict(conflict)
    );

    mai_issue_pick #(.N_ENT(N_ENT), .KIND(K_MATCH)) u_mpick (
        .clk(clk), .rst(rst), .tbl(tbl), .age_v(age_v), .age_c(age_c),
        .hit(mhit), .iss(m_iss)
    );

    mai_issue_pick #(.N_ENT(N_ENT), .KIND(K_ACTION)) u_apick (
        .clk(clk), .rst(rst), .tbl(tbl), .age_v(age_v), .age_c(age_c),
        .hit(ahit), .iss(a_iss)
    );

    always_ff @(posedge clk) begin
        if (rst)           sched_violation <= 1'b0;
        else if (conflict) sched_violation <= 1'b1;
    end

    assign mat_issue = m_iss.vld;
    assign mat_op    = m_iss.idx;
    assign mat_ctx   = m_iss.ctx;
    assign act_issue = a_iss.vld;
    assign act_op    = a_iss.idx;
    assign act_ctx   = a_iss.ctx;

endmodule

// File: rtl/mai_chk.sv
module mai_chk #(
    parameter int N_ENT = 32,
    parameter int TW    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             busy,
    input logic [TW-1:0]    tbl_flat,
    input logic             conflict,
    input logic [N_ENT-1:0] mhit,
    input logic [N_ENT-1:0] ahit,
    input logic             mat_issue,
    input logic             act_issue,
    input logic             sched_violation
);

    AST_VIO_STICKY: assert property (@(posedge clk) disable iff (rst)
        sched_violation |=> sched_violation); // R8

    AST_VIO_RAISE: assert property (@(posedge clk) disable iff (rst)
        conflict |=> sched_violation); // R8

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && busy) |=> $stable(tbl_flat)); // R7

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        !conflict |-> $onehot0(mhit)); // R2

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        !conflict |-> $onehot0(ahit)); // R3

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (!mat_issue && !act_issue)); // R4

    AST_MATCH_FROM_HIT: assert property (@(posedge clk) disable iff (rst)
        mat_issue |-> $past(|mhit)); // R2

    AST_ACTION_FROM_HIT: assert property (@(posedge clk) disable iff (rst)
        act_issue |-> $past(|ahit)); // R3

endmodule

bind periodic_issue_ctl mai_chk #(.N_ENT(N_ENT), .TW(N_ENT*EW)) i_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .busy(busy), .tbl_flat(tbl_flat),
    .conflict(conflict), .mhit(mhit), .ahit(ahit), .mat_issue(mat_issue),
    .act_issue(act_issue), .sched_violation(sched_violation)
);

// File: tb/test_periodic_issue_ctl.sv
module test_periodic_issue_ctl;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       arr_valid = 1'b0;
    logic [7:0] arr_ctx = '0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [1:0] cfg_kind = '0;
    logic [4:0] cfg_off = '0;
    logic [5:0] cfg_opidx = '0;
    logic       mat_issue, act_issue, sched_violation;
    logic [5:0] mat_op, act_op;
    logic [7:0] mat_ctx, act_ctx;

    int checks = 0;
    int fails  = 0;
    int ecnt   = 0;
    bit done   = 0;

    logic [1:0] m_kind [32];
    logic [4:0] m_off  [32];
    logic [5:0] m_idx  [32];
    bit         arr_v  [8192];
    logic [7:0] arr_c  [8192];

    periodic_issue_ctl i_periodic_issue_ctl (
        .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_ctx(arr_ctx),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_kind(cfg_kind),
        .cfg_off(cfg_off), .cfg_opidx(cfg_opidx),
        .mat_issue(mat_issue), .mat_op(mat_op), .mat_ctx(mat_ctx),
        .act_issue(act_issue), .act_op(act_op), .act_ctx(act_ctx),
        .sched_violation(sched_violation)
    );

    always #10 clk = ~clk;
    always @(posedge clk) ecnt <= ecnt + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, ecnt);
        end
    endtask

    task automatic clear_model();
        for (int e = 0; e < 32; e++) begin
            m_kind[e] = 2'd0; m_off[e] = '0; m_idx[e] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    task automatic write_entry(input int a, input logic [1:0] k, input logic [4:0] o, input logic [5:0] x);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_kind = k; cfg_off = o; cfg_opidx = x;
        @(negedge clk);
        cfg_we = 1'b0;
        m_kind[a] = k; m_off[a] = o; m_idx[a] = x;
    endtask

    function automatic logic [14:0] model_issue(input int k, input logic [1:0] kind);
        for (int e = 0; e < 32; e++) begin
            if (m_kind[e] == kind && (k - int'(m_off[e])) >= 1 && arr_v[k - int'(m_off[e])])
                return {1'b1, m_idx[e], arr_c[k - int'(m_off[e])]};
        end
        return '0;
    endfunction

    task automatic compare(input string tag);
        logic [14:0] em, ea, gm, ga;
        em = model_issue(ecnt, 2'd1);
        ea = model_issue(ecnt, 2'd2);
        gm = mat_issue ? {1'b1, mat_op, mat_ctx} : 15'd0;
        ga = act_issue ? {1'b1, act_op, act_ctx} : 15'd0;
        check(gm == em, {tag, " match"}, 32'(gm), 32'(em));
        check(ga == ea, {tag, " action"}, 32'(ga), 32'(ea));
    endtask

    task automatic run_stream(input int n, input int gap, input logic [7:0] cbase, input string tag, input int busy_wr_at);
        int total;
        total = n * gap + 40;
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            compare(tag);
            arr_valid = (i < n * gap) && (i % gap == 0);
            arr_ctx   = cbase + 8'(i / gap);
            if (arr_valid) begin
                arr_v[ecnt + 1] = 1'b1;
                arr_c[ecnt + 1] = arr_ctx;
            end
            cfg_we = (i == busy_wr_at);
            if (cfg_we) begin
                cfg_addr = 5'd4; cfg_kind = 2'd1; cfg_off = 5'd2; cfg_opidx = 6'd20;
            end
        end
        arr_valid = 1'b0;
        cfg_we    = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(!mat_issue && !act_issue, "R1 issue", {act_issue, mat_issue}, 0);
        check(!sched_violation, "R1 violation", sched_violation, 0);
    endtask

    task automatic t_empty_table();
        run_stream(3, 2, 8'h10, "R1 R4", -1);
    endtask

    task automatic t_single();
        write_entry(0, 2'd1, 5'd0, 6'd5);
        write_entry(1, 2'd2, 5'd1, 6'd9);
        write_entry(2, 2'd1, 5'd3, 6'd7);
        write_entry(3, 2'd2, 5'd6, 6'd12);
        write_entry(4, 2'd0, 5'd2, 6'd33);
        repeat (2) @(negedge clk);
        check(!sched_violation, "R9 legal cross pair", sched_violation, 0);
        run_stream(1, 2, 8'hA1, "R2 R3 R4", -1);
    endtask

    task automatic t_overlap();
        run_stream(6, 2, 8'h20, "R5 R6", -1);
    endtask

    task automatic t_busy_write();
        run_stream(3, 2, 8'h40, "R7", 3);
        repeat (2) @(negedge clk);
        check(!sched_violation, "R7 no table change", sched_violation, 0);
        run_stream(1, 2, 8'h50, "R7", -1);
    endtask

    task automatic t_match_conflict();
        write_entry(5, 2'd1, 5'd4, 6'd3);
        repeat (2) @(negedge clk);
        check(sched_violation, "R8 match pair", sched_violation, 1);
        write_entry(5, 2'd0, 5'd4, 6'd3);
        repeat (3) @(negedge clk);
        check(sched_violation, "R8 sticky", sched_violation, 1);
        do_reset();
        @(negedge clk);
        check(!sched_violation, "R10 violation cleared", sched_violation, 0);
        run_stream(1, 2, 8'h60, "R10", -1);
    endtask

    task automatic t_action_conflict();
        write_entry(0, 2'd2, 5'd1, 6'd1);
        write_entry(1, 2'd2, 5'd3, 6'd2);
        repeat (2) @(negedge clk);
        check(sched_violation, "R8 action pair", sched_violation, 1);
        do_reset();
    endtask

    initial begin
        clear_model();
        for (int i = 0; i < 8192; i++) begin
            arr_v[i] = 1'b0; arr_c[i] = '0;
        end
        do_reset();
        t_reset_state();
        t_empty_table();
        t_single();
        t_overlap();
        t_busy_write();
        t_match_conflict();
        t_action_conflict();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule